// File: doc/BRIEF.md
# Interrupt Controller with Master Enable and Halt Wake

This block collects up to 32 one-cycle request pulses from peripherals and turns them into one level-sensitive interrupt line for a single processor. Each request latches a sticky flag. A per-source enable mask and a one-bit master switch decide whether the latched flags reach the processor. Software reads and writes the registers through a 16-bit port, one halfword at a time. It acknowledges a request by writing ones to the flag bits it has serviced.

The controller also tracks the processor's halted state. The processor enters halt through a request input. Any raised source whose enable bit is set releases the halt, whatever the master switch says. The interrupt line is gated by the master switch and by the processor's interrupt-disable bit. A pending request that is held back by that bit stays pending and is delivered once the bit drops.

Top module: `intc_top`

## Requirements
- R1: After a synchronous reset, the master switch, both enable halves and both flag halves read zero, `cpu_irq` is low and `cpu_halted` is low.
- R2: A high on `src_pulse[n]` sets flag n at the next clock edge, whatever the state of the enable mask or the master switch.
- R3: Writing the flag registers clears every flag bit written as 1 and leaves every bit written as 0 unchanged. Address 3 holds sources 0 to 15 and address 4 holds sources 16 to 31, with bit k of the halfword mapped to source k of that half.
- R4: When a source is raised in the same cycle as a write that clears its flag, the flag ends up set.
- R5: `cpu_irq` is a registered level. It is high in the cycle after a clock edge exactly when, after that edge, the master switch is 1 and the enable mask and the flags overlap in at least one bit, and `cpu_mask` was low at that edge. It stays high until the overlapping flags are cleared.
- R6: When the master switch is on, writing an enable half that overlaps pending flags raises `cpu_irq` at that write's clock edge.
- R7: The master switch lives at address 0 and only bit 0 of the written data is stored. Writing 1 while enabled flags are pending raises `cpu_irq`. Writing 0, or a value with bit 0 clear, drops it.
- R8: While `cpu_mask` is high, `cpu_irq` stays low and the pending flags are kept. Once `cpu_mask` goes low, `cpu_irq` rises at the next edge.
- R9: A high on `halt_req` sets `cpu_halted`. A raised source whose enable bit is set clears `cpu_halted` even when the master switch is 0, and a raised source that is not enabled leaves it set. If both happen in the same cycle, the release wins.
- R10: Reads are registered. `rd_data` shows, one edge after `rd_addr` is presented, the register at that address: 0 for the master switch in bit 0, 1 and 2 for the low and high enable halves, 3 and 4 for the low and high flag halves. Any other address reads zero.
- R11: Writing address 1 loads the enable bits of sources 0 to 15 and writing address 2 loads those of sources 16 to 31, each without touching the other half.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_pulse | input | 32 | Request pulses, one bit per source |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Registered read data |
| cpu_mask | input | 1 | Processor interrupt-disable bit |
| halt_req | input | 1 | Processor asks to enter halt |
| cpu_irq | output | 1 | Interrupt level to the processor |
| cpu_halted | output | 1 | Processor halted state |

## Verification
The bench goes after the re-evaluation paths. A design that samples the interrupt only when a source is raised would miss the rise caused by an enable write or a master write, because no new pulse arrives then. It also checks that only bit 0 of the master switch counts: a design that tests the whole written value would assert the line after a write of 2. The bench checks the same-cycle race between acknowledge and a new request, where a clear-wins design silently loses an event. It also checks halt release with the master switch off: a design that wakes from the gated interrupt line would leave the processor asleep.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int unsigned HALF_W      = 16;
  localparam int unsigned ADDR_W      = 3;
  localparam int unsigned MASTER_ADDR = 0;
  localparam int unsigned EN_BASE     = 1;
endpackage

// File: rtl/intc_flags.sv
module intc_flags #(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned HALF_W  = intc_pkg::HALF_W,
  parameter int unsigned ADDR_W  = intc_pkg::ADDR_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [HALF_W-1:0]  wr_data,
  output logic [NUM_SRC-1:0] flg_q,
  output logic [NUM_SRC-1:0] flg_n
);
  localparam int unsigned NUM_HALF = NUM_SRC / HALF_W;
  localparam int unsigned FLG_BASE = intc_pkg::EN_BASE + NUM_HALF;

  logic [NUM_SRC-1:0] clr;

  for (genvar h = 0; h < NUM_HALF; h++) begin : g_half
    assign clr[h*HALF_W +: HALF_W] =
      (wr_en && wr_addr == ADDR_W'(FLG_BASE + h)) ? wr_data : '0;
  end

  // a new request outranks an acknowledge of the same bit
  assign flg_n = (flg_q & ~clr) | src;

  always_ff @(posedge clk) begin
    if (rst) flg_q <= '0;
    else     flg_q <= flg_n;
  end

  // R2
  raise_sets_chk: assert property (@(posedge clk) disable iff (rst)
    (src != '0) |=> ((flg_q & $past(src)) == $past(src)));

  // R3
  ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
    ((clr & ~src) != '0) |=> ((flg_q & $past(clr & ~src)) == '0));
endmodule

// File: rtl/intc_enables.sv
module intc_enables #(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned HALF_W  = intc_pkg::HALF_W,
  parameter int unsigned ADDR_W  = intc_pkg::ADDR_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [HALF_W-1:0]  wr_data,
  output logic               men_q,
  output logic               men_n,
  output logic [NUM_SRC-1:0] en_q,
  output logic [NUM_SRC-1:0] en_n
);
  localparam int unsigned NUM_HALF = NUM_SRC / HALF_W;

  assign men_n = (wr_en && wr_addr == ADDR_W'(intc_pkg::MASTER_ADDR))
                 ? wr_data[0] : men_q;

  for (genvar h = 0; h < NUM_HALF; h++) begin : g_half
    assign en_n[h*HALF_W +: HALF_W] =
      (wr_en && wr_addr == ADDR_W'(intc_pkg::EN_BASE + h))
      ? wr_data : en_q[h*HALF_W +: HALF_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      men_q <= 1'b0;
      en_q  <= '0;
    end else begin
      men_q <= men_n;
      en_q  <= en_n;
    end
  end

  // R11
  en_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(en_q));
endmodule

// File: rtl/intc_halt.sv
module intc_halt #(
  parameter int unsigned NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src,
  input  logic [NUM_SRC-1:0] en_q,
  input  logic               halt_req,
  output logic               halted_q
);
  logic wake;

  // release ignores the master switch on purpose
  assign wake = (src & en_q) != '0;

  always_ff @(posedge clk) begin
    if (rst)           halted_q <= 1'b0;
    else if (wake)     halted_q <= 1'b0;
    else if (halt_req) halted_q <= 1'b1;
  end

  // R9
  wake_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(halted_q) |-> $past(wake));

  // R9
  halt_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(halted_q) |-> $past(halt_req));
endmodule

// File: rtl/intc_top.sv
module intc_top #(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned HALF_W  = intc_pkg::HALF_W,
  parameter int unsigned ADDR_W  = intc_pkg::ADDR_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_pulse,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [HALF_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [HALF_W-1:0]  rd_data,
  input  logic               cpu_mask,
  input  logic               halt_req,
  output logic               cpu_irq,
  output logic               cpu_halted
);
  localparam int unsigned NUM_HALF = NUM_SRC / HALF_W;
  localparam int unsigned FLG_BASE = intc_pkg::EN_BASE + NUM_HALF;

  logic               men_q, men_n;
  logic [NUM_SRC-1:0] en_q, en_n, flg_q, flg_n;
  logic [HALF_W-1:0]  rd_mux;

  intc_enables #(.NUM_SRC(NUM_SRC), .HALF_W(HALF_W), .ADDR_W(ADDR_W)) u_en (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .men_q(men_q), .men_n(men_n), .en_q(en_q), .en_n(en_n));

  intc_flags #(.NUM_SRC(NUM_SRC), .HALF_W(HALF_W), .ADDR_W(ADDR_W)) u_flg (
    .clk(clk), .rst(rst), .src(src_pulse), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .flg_q(flg_q), .flg_n(flg_n));

  intc_halt #(.NUM_SRC(NUM_SRC)) u_halt (
    .clk(clk), .rst(rst), .src(src_pulse), .en_q(en_q),
    .halt_req(halt_req), .halted_q(cpu_halted));

  // level is built from next-state values so every write re-evaluates it
  always_ff @(posedge clk) begin
    if (rst) cpu_irq <= 1'b0;
    else     cpu_irq <= men_n && ((en_n & flg_n) != '0) && !cpu_mask;
  end

  always_comb begin
    rd_mux = '0;
    if (rd_addr == ADDR_W'(intc_pkg::MASTER_ADDR)) rd_mux[0] = men_q;
    for (int h = 0; h < NUM_HALF; h++) begin
      if (rd_addr == ADDR_W'(intc_pkg::EN_BASE + h))
        rd_mux = en_q[h*HALF_W +: HALF_W];
      if (rd_addr == ADDR_W'(FLG_BASE + h))
        rd_mux = flg_q[h*HALF_W +: HALF_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_mux;
  end

  // R5
  irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_irq |-> (men_q && ((en_q & flg_q) != '0)));

  // R8
  irq_masked_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_irq |-> !$past(cpu_mask));
endmodule

// File: tb/intc_top_tb.sv
module intc_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int VW = 55;
  localparam int NV = 13;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] src_pulse = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        cpu_mask = 1'b0;
  logic        halt_req = 1'b0;
  logic        cpu_irq;
  logic        cpu_halted;

  int n_vec = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  intc_top u_dut (
    .clk(clk), .rst(rst), .src_pulse(src_pulse), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .cpu_mask(cpu_mask), .halt_req(halt_req), .cpu_irq(cpu_irq),
    .cpu_halted(cpu_halted));

  // {op: 1 write / 2 pulse / 0 idle, addr, data, src, mask, expected irq}
  localparam logic [VW-1:0] VEC [NV] = '{
    {2'd2, 3'd0, 16'h0000, 32'h0000_0008, 1'b0, 1'b0}, // R2 flag set, not enabled
    {2'd1, 3'd1, 16'h0008, 32'h0000_0000, 1'b0, 1'b0}, // R11 enable, master off
    {2'd1, 3'd0, 16'h0001, 32'h0000_0000, 1'b0, 1'b1}, // R7 master on with pending
    {2'd1, 3'd3, 16'h0008, 32'h0000_0000, 1'b0, 1'b0}, // R3 acknowledge low
    {2'd2, 3'd0, 16'h0000, 32'h0010_0000, 1'b0, 1'b0}, // R2 high source, not enabled
    {2'd1, 3'd2, 16'h0010, 32'h0000_0000, 1'b0, 1'b1}, // R6 enable write re-evaluates
    {2'd0, 3'd0, 16'h0000, 32'h0000_0000, 1'b1, 1'b0}, // R8 held back
    {2'd0, 3'd0, 16'h0000, 32'h0000_0000, 1'b0, 1'b1}, // R8 delivered
    {2'd1, 3'd0, 16'h0000, 32'h0000_0000, 1'b0, 1'b0}, // R7 master off
    {2'd1, 3'd0, 16'h0002, 32'h0000_0000, 1'b0, 1'b0}, // R7 only bit 0 counts
    {2'd1, 3'd0, 16'h0001, 32'h0000_0000, 1'b0, 1'b1}, // R7 master on again
    {2'd1, 3'd4, 16'h0000, 32'h0000_0000, 1'b0, 1'b1}, // R3 zero write no effect
    {2'd1, 3'd4, 16'h0010, 32'h0000_0000, 1'b0, 1'b0}  // R3 acknowledge high, R5 drops
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive one cycle of stimulus at a falling edge, return at the next falling edge
  task automatic step(input logic we, input logic [2:0] a, input logic [15:0] d,
                      input logic [31:0] s, input logic m, input logic h);
    wr_en = we; wr_addr = a; wr_data = d; src_pulse = s; cpu_mask = m; halt_req = h;
    @(negedge clk);
    wr_en = 1'b0; src_pulse = '0; cpu_mask = 1'b0; halt_req = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    rd_addr = a;
    @(negedge clk);
    v = rd_data;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 irq", 32'(cpu_irq), 32'd0);
    check("R1 halted", 32'(cpu_halted), 32'd0);
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v);
      check("R1 register", 32'(v), 32'd0);
    end

    // table walk
    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] e;
      e = VEC[i];
      step(e[54:53] == 2'd1, e[52:50], e[49:34],
           (e[54:53] == 2'd2) ? e[33:2] : 32'h0, e[1], 1'b0);
      n_vec++;
      if (cpu_irq !== e[0]) begin
        n_bad++;
        $display("FAIL R5 vector %0d actual=%0b expected=%0b", i, cpu_irq, e[0]);
      end
    end

    // R2 R10 flag readback per half
    step(1'b0, 3'd0, 16'h0, 32'h0003_0005, 1'b0, 1'b0);
    rd(3'd3, v); check("R2 R10 flag low", 32'(v), 32'h0005);
    rd(3'd4, v); check("R2 R10 flag high", 32'(v), 32'h0003);
    step(1'b1, 3'd3, 16'h0004, 32'h0, 1'b0, 1'b0);
    rd(3'd3, v); check("R3 partial clear", 32'(v), 32'h0001);
    rd(3'd2, v); check("R11 enable high", 32'(v), 32'h0010);
    rd(3'd1, v); check("R11 enable low", 32'(v), 32'h0008);
    rd(3'd0, v); check("R10 master", 32'(v), 32'h0001);
    rd(3'd7, v); check("R10 unused address", 32'(v), 32'h0000);

    // R4 raise beats same-cycle acknowledge
    step(1'b1, 3'd3, 16'h0001, 32'h0000_0001, 1'b0, 1'b0);
    rd(3'd3, v); check("R4 raise wins", 32'(v), 32'h0001);
    step(1'b1, 3'd3, 16'hFFFF, 32'h0, 1'b0, 1'b0);
    step(1'b1, 3'd4, 16'hFFFF, 32'h0, 1'b0, 1'b0);
    rd(3'd3, v); check("R3 cleared low", 32'(v), 32'h0000);
    rd(3'd4, v); check("R3 cleared high", 32'(v), 32'h0000);

    // R9 halt and wake with master off
    step(1'b1, 3'd0, 16'h0000, 32'h0, 1'b0, 1'b0);
    step(1'b0, 3'd0, 16'h0, 32'h0, 1'b0, 1'b1);
    check("R9 halt entered", 32'(cpu_halted), 32'd1);
    step(1'b0, 3'd0, 16'h0, 32'h0000_0020, 1'b0, 1'b0);
    check("R9 unenabled source keeps halt", 32'(cpu_halted), 32'd1);
    step(1'b0, 3'd0, 16'h0, 32'h0000_0008, 1'b0, 1'b1);
    check("R9 enabled source wakes", 32'(cpu_halted), 32'd0);
    check("R9 irq stays low, master off", 32'(cpu_irq), 32'd0);
    rd(3'd3, v); check("R9 R2 flags latched", 32'(v), 32'h0028);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule